// File: doc/BRIEF.md
# Boot Acknowledge Checker

This block governs the receive side of a boot-mode read from an embedded flash card. A write to the command register arms it, but only while the two-bit command type field holds the boot code. When acknowledge checking is enabled, the block watches the sampled data line 0. It keeps the boot data path closed until it has seen a well-formed acknowledge token. When checking is disabled, the data path opens straight after arming.

There are three possible outcomes: a correct token, a malformed token, or no start bit before a programmable cycle limit expires. Each of the two errors has its own sticky status flag, a status-enable bit that gates the setting of that flag, and an interrupt-enable bit. The interrupt output combines the flags with their interrupt enables. Software clears a flag by writing 1 to it. After either error the block goes idle and ignores data line 0 until the next boot arming.

Top module: `bootAckCheck`

## Requirements
- R1: A command write arms the block only when cmdType equals 3 (boot). Writes with type 0 (normal), 1 (wait-interrupt) or 2 (stream) leave dataAccept low and set no flag, whatever data line 0 does.
- R2: With ackEnable low, dataAccept is high from the cycle after the arming write.
- R3: With ackEnable high, dataAccept stays low until a valid token has been received. The token is a start bit 0 followed by the bits 0, 1, 0, 1 on successive cycles. dataAccept rises in the cycle after the last of these bits is sampled.
- R4: If the four bits after the start bit differ from 0,1,0,1, statusFlags bit 0 (ack error) is set in the cycle after the last bit. The set happens only if statusEnable bit 0 is 1. The block then returns to idle with dataAccept low.
- R5: If data line 0 stays high for timeoutLimit consecutive sampled cycles after arming, statusFlags bit 1 (timeout) is set after the last of those cycles. The set happens only if statusEnable bit 1 is 1. The flag is not set one cycle earlier.
- R6: An error whose statusEnable bit is 0 leaves its flag clear.
- R7: irq equals the OR over both bits of statusFlags AND irqEnable.
- R8: Flags are sticky. A clearWrite with clearMask bit n set clears flag n one cycle later. If a set and a clear of the same flag fall in one cycle, the set wins.
- R9: After an error, changes on data line 0 alter neither statusFlags nor dataAccept until the next arming.
- R10: A command write with a non-boot type while dataAccept is high drops dataAccept in the next cycle.
- R11: After reset, dataAccept, statusFlags and irq are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdWrite | input | 1 | Command register write strobe |
| cmdType | input | 2 | Command type field (3 = boot) |
| ackEnable | input | 1 | Require acknowledge token before data |
| dat0Sample | input | 1 | Sampled data line 0 |
| timeoutLimit | input | TIMER_W | Cycles to wait for the start bit |
| statusEnable | input | 2 | Flag set enables: bit 0 ack error, bit 1 timeout |
| irqEnable | input | 2 | Interrupt enables, same bit order |
| clearWrite | input | 1 | Flag clear strobe |
| clearMask | input | 2 | Write-1-to-clear mask |
| dataAccept | output | 1 | Boot data path open |
| statusFlags | output | 2 | Sticky flags: bit 0 ack error, bit 1 timeout |
| irq | output | 1 | Interrupt request |

## Verification
Error detection and a software flag clear can land on the same clock edge. The bench times a clearWrite so that the edge sampling it is the same edge on which the timeout expires. It then expects the timeout flag to read 1 afterwards, and expects it to drop only on a later clear that is not contested by a set. A partial clear of the other bit in between must leave the timeout flag untouched.

// File: rtl/bootAckPkg.sv
package bootAckPkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_RECV,
    ST_DATA
  } bootState_t;

  typedef struct packed {
    logic loadTimer;
    logic countTimer;
    logic clearBits;
    logic shiftBit;
    logic setAckErr;
    logic setTimeout;
  } dpCtrl_t;

  localparam logic [1:0] CMD_BOOT = 2'b11;
  localparam int FLAG_ACKERR = 0;
  localparam int FLAG_TIMEOUT = 1;
  localparam int NUM_FLAGS = 2;
endpackage

// File: rtl/bootAckCtrl.sv
module bootAckCtrl
  import bootAckPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdWrite,
  input  logic [1:0] cmdType,
  input  logic       ackEnable,
  input  logic       dat0Sample,
  input  logic       timerExpired,
  input  logic       bitsDone,
  input  logic       patternOk,
  output dpCtrl_t    ctrl,
  output logic       dataAccept
);
  bootState_t state, nextState;

  always_comb begin
    nextState = state;
    ctrl = '0;
    if (cmdWrite) begin
      if (cmdType == CMD_BOOT) begin
        if (ackEnable) begin
          nextState = ST_WAIT;
          ctrl.loadTimer = 1'b1;
        end else begin
          nextState = ST_DATA;
        end
      end else begin
        nextState = ST_IDLE;
      end
    end else begin
      case (state)
        ST_WAIT: begin
          if (!dat0Sample) begin
            nextState = ST_RECV;
            ctrl.clearBits = 1'b1;
          end else if (timerExpired) begin
            nextState = ST_IDLE;
            ctrl.setTimeout = 1'b1;
          end else begin
            ctrl.countTimer = 1'b1;
          end
        end
        ST_RECV: begin
          ctrl.shiftBit = 1'b1;
          if (bitsDone) begin
            if (patternOk) begin
              nextState = ST_DATA;
            end else begin
              nextState = ST_IDLE;
              ctrl.setAckErr = 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  assign dataAccept = (state == ST_DATA);
endmodule

// File: rtl/bootAckDatapath.sv
module bootAckDatapath
  import bootAckPkg::*;
#(
  parameter int TIMER_W = 16,
  parameter int ACK_BITS = 4,
  parameter logic [ACK_BITS-1:0] ACK_PATTERN = 4'b0101
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dpCtrl_t              ctrl,
  input  logic                 dat0Sample,
  input  logic [TIMER_W-1:0]   timeoutLimit,
  input  logic [NUM_FLAGS-1:0] statusEnable,
  input  logic [NUM_FLAGS-1:0] irqEnable,
  input  logic                 clearWrite,
  input  logic [NUM_FLAGS-1:0] clearMask,
  output logic                 timerExpired,
  output logic                 bitsDone,
  output logic                 patternOk,
  output logic [NUM_FLAGS-1:0] statusFlags,
  output logic                 irq
);
  localparam int CNT_W = (ACK_BITS > 1) ? $clog2(ACK_BITS) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(ACK_BITS - 1);

  logic [TIMER_W-1:0]   waitCount;
  logic [CNT_W-1:0]     bitCount;
  logic [ACK_BITS-2:0]  shiftReg;
  logic [ACK_BITS-1:0]  candidate;
  logic [NUM_FLAGS-1:0] setReq;

  always_ff @(posedge clk) begin
    if (!rstN)                waitCount <= '0;
    else if (ctrl.loadTimer)  waitCount <= '0;
    else if (ctrl.countTimer) waitCount <= waitCount + 1'b1;
  end

  assign timerExpired = ({1'b0, waitCount} + 1'b1) >= {1'b0, timeoutLimit};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCount <= '0;
      shiftReg <= '0;
    end else if (ctrl.clearBits) begin
      bitCount <= '0;
      shiftReg <= '0;
    end else if (ctrl.shiftBit) begin
      bitCount <= bitCount + 1'b1;
      shiftReg <= candidate[ACK_BITS-2:0];
    end
  end

  assign candidate = {shiftReg, dat0Sample};
  assign patternOk = (candidate == ACK_PATTERN);
  assign bitsDone  = (bitCount == LAST_BIT);

  always_comb begin
    setReq = '0;
    setReq[FLAG_ACKERR]  = ctrl.setAckErr;
    setReq[FLAG_TIMEOUT] = ctrl.setTimeout;
  end

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rstN)                             statusFlags[i] <= 1'b0;
      else if (setReq[i] && statusEnable[i]) statusFlags[i] <= 1'b1;
      else if (clearWrite && clearMask[i])   statusFlags[i] <= 1'b0;
    end
  end

  assign irq = |(statusFlags & irqEnable);
endmodule

// File: rtl/bootAckCheck.sv
module bootAckCheck
  import bootAckPkg::*;
#(
  parameter int TIMER_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cmdWrite,
  input  logic [1:0]         cmdType,
  input  logic               ackEnable,
  input  logic               dat0Sample,
  input  logic [TIMER_W-1:0] timeoutLimit,
  input  logic [1:0]         statusEnable,
  input  logic [1:0]         irqEnable,
  input  logic               clearWrite,
  input  logic [1:0]         clearMask,
  output logic               dataAccept,
  output logic [1:0]         statusFlags,
  output logic               irq
);
  dpCtrl_t ctrl;
  logic    timerExpired;
  logic    bitsDone;
  logic    patternOk;

  bootAckCtrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .cmdWrite     (cmdWrite),
    .cmdType      (cmdType),
    .ackEnable    (ackEnable),
    .dat0Sample   (dat0Sample),
    .timerExpired (timerExpired),
    .bitsDone     (bitsDone),
    .patternOk    (patternOk),
    .ctrl         (ctrl),
    .dataAccept   (dataAccept)
  );

  bootAckDatapath #(
    .TIMER_W (TIMER_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .ctrl         (ctrl),
    .dat0Sample   (dat0Sample),
    .timeoutLimit (timeoutLimit),
    .statusEnable (statusEnable),
    .irqEnable    (irqEnable),
    .clearWrite   (clearWrite),
    .clearMask    (clearMask),
    .timerExpired (timerExpired),
    .bitsDone     (bitsDone),
    .patternOk    (patternOk),
    .statusFlags  (statusFlags),
    .irq          (irq)
  );
endmodule

// File: rtl/bootAckCheckAsserts.sv
module bootAckCheckAsserts (
  input logic       clk,
  input logic       rstN,
  input logic       cmdWrite,
  input logic [1:0] cmdType,
  input logic       ackEnable,
  input logic [1:0] statusEnable,
  input logic       clearWrite,
  input logic [1:0] clearMask,
  input logic       dataAccept,
  input logic [1:0] statusFlags,
  input logic       irq
);
  assert_no_arm_R1: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWrite && cmdType != 2'b11) |=> !dataAccept);

  assert_direct_open_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWrite && cmdType == 2'b11 && !ackEnable) |=> dataAccept);

  assert_gate_closed_R3: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWrite && cmdType == 2'b11 && ackEnable) |=> !dataAccept);

  assert_ackerr_enabled_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusFlags[0]) |-> $past(statusEnable[0]));

  assert_timeout_enabled_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusFlags[1]) |-> $past(statusEnable[1]));

  assert_irq_needs_flag_R7: assert property (@(posedge clk) disable iff (!rstN)
    (statusFlags == 2'b00) |-> !irq);

  assert_clear_cause_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(statusFlags[0]) |-> $past(clearWrite && clearMask[0]));
endmodule

bind bootAckCheck bootAckCheckAsserts u_asserts (
  .clk          (clk),
  .rstN         (rstN),
  .cmdWrite     (cmdWrite),
  .cmdType      (cmdType),
  .ackEnable    (ackEnable),
  .statusEnable (statusEnable),
  .clearWrite   (clearWrite),
  .clearMask    (clearMask),
  .dataAccept   (dataAccept),
  .statusFlags  (statusFlags),
  .irq          (irq)
);

// File: tb/bootAckCheck_test.sv
`timescale 1ns/1ps
module bootAckCheck_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdWrite = 1'b0;
  logic [1:0]  cmdType = 2'b00;
  logic        ackEnable = 1'b0;
  logic        dat0Sample = 1'b1;
  logic [15:0] timeoutLimit = 16'd4;
  logic [1:0]  statusEnable = 2'b00;
  logic [1:0]  irqEnable = 2'b00;
  logic        clearWrite = 1'b0;
  logic [1:0]  clearMask = 2'b00;
  logic        dataAccept;
  logic [1:0]  statusFlags;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  bootAckCheck uut (
    .clk(clk), .rstN(rstN), .cmdWrite(cmdWrite), .cmdType(cmdType),
    .ackEnable(ackEnable), .dat0Sample(dat0Sample), .timeoutLimit(timeoutLimit),
    .statusEnable(statusEnable), .irqEnable(irqEnable), .clearWrite(clearWrite),
    .clearMask(clearMask), .dataAccept(dataAccept), .statusFlags(statusFlags),
    .irq(irq)
  );

  function automatic logic expIrq(logic [1:0] f, logic [1:0] ie);
    return |(f & ie);
  endfunction

  task automatic check(string req, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic arm();
    cmdWrite = 1'b1;
    cmdType = 2'b11;
    @(negedge clk);
    cmdWrite = 1'b0;
    cmdType = 2'b00;
  endtask

  task automatic clearAll();
    clearWrite = 1'b1;
    clearMask = 2'b11;
    @(negedge clk);
    clearWrite = 1'b0;
    clearMask = 2'b00;
  endtask

  // kind: 0 good token, 1 wrong token, 2 no token
  task automatic trial(int kind, bit ack, logic [1:0] se, logic [1:0] ie, int lim);
    logic [3:0] tok;
    logic [1:0] expFlags = 2'b00;
    logic expAcc = 1'b0;
    statusEnable = se;
    irqEnable = ie;
    ackEnable = ack;
    timeoutLimit = 16'(lim);
    dat0Sample = 1'b1;
    arm();
    if (!ack) begin
      check("R2 direct open", {3'b0, dataAccept}, 4'd1);
      expAcc = 1'b1;
    end else begin
      check("R3 closed after arm", {3'b0, dataAccept}, 4'd0);
      if (kind == 2) begin
        repeat (lim - 1) @(negedge clk);
        check("R5 not early", {3'b0, statusFlags[1]}, 4'd0);
        @(negedge clk);
        expFlags[1] = se[1];
      end else begin
        if (kind == 0) tok = 4'b0101;
        else do tok = 4'($urandom); while (tok == 4'b0101);
        dat0Sample = 1'b0;
        @(negedge clk);
        for (int i = 3; i >= 0; i--) begin
          dat0Sample = tok[i];
          @(negedge clk);
          if (i > 0) check("R3 closed during token", {3'b0, dataAccept}, 4'd0);
        end
        dat0Sample = 1'b1;
        expAcc = (kind == 0);
        expFlags[0] = (kind == 1) && se[0];
      end
    end
    check("R3/R4 data gate", {3'b0, dataAccept}, {3'b0, expAcc});
    check("R4/R5/R6 flags", {2'b0, statusFlags}, {2'b0, expFlags});
    check("R7 irq", {3'b0, irq}, {3'b0, expIrq(expFlags, ie)});
    repeat (6) begin
      dat0Sample = 1'($urandom);
      @(negedge clk);
    end
    dat0Sample = 1'b1;
    check("R9 idle ignores line", {2'b0, statusFlags, dataAccept}, {2'b0, expFlags, expAcc});
    if (expAcc) begin
      cmdWrite = 1'b1;
      cmdType = 2'($urandom % 3);
      @(negedge clk);
      cmdWrite = 1'b0;
      cmdType = 2'b00;
      check("R10 abort", {3'b0, dataAccept}, 4'd0);
    end
    clearAll();
    check("R8 clear all", {2'b0, statusFlags}, 4'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    check("R11 reset state", {1'b0, dataAccept, statusFlags}, 4'd0);
    check("R11 reset irq", {3'b0, irq}, 4'd0);

    // R1: non-boot types never arm
    statusEnable = 2'b11;
    for (int t = 0; t < 3; t++) begin
      ackEnable = t[0];
      cmdWrite = 1'b1;
      cmdType = 2'(t);
      @(negedge clk);
      cmdWrite = 1'b0;
      cmdType = 2'b00;
      dat0Sample = 1'b0;
      repeat (3) @(negedge clk);
      dat0Sample = 1'b1;
      repeat (8) @(negedge clk);
      check("R1 no arm", {1'b0, dataAccept, statusFlags}, 4'd0);
    end

    // directed trials
    trial(0, 1'b1, 2'b11, 2'b11, 5);
    trial(1, 1'b1, 2'b11, 2'b01, 5);
    trial(1, 1'b1, 2'b10, 2'b11, 5);
    trial(2, 1'b1, 2'b11, 2'b10, 1);
    trial(2, 1'b1, 2'b01, 2'b11, 7);
    trial(0, 1'b0, 2'b11, 2'b11, 5);

    // R8: set and clear of the timeout flag on the same edge, set wins
    statusEnable = 2'b11;
    irqEnable = 2'b10;
    ackEnable = 1'b1;
    timeoutLimit = 16'd5;
    dat0Sample = 1'b1;
    arm();
    repeat (4) @(negedge clk);
    clearWrite = 1'b1;
    clearMask = 2'b10;
    @(negedge clk);
    clearWrite = 1'b0;
    clearMask = 2'b00;
    check("R8 set wins", {2'b0, statusFlags}, 4'b0010);
    check("R7 irq on timeout", {3'b0, irq}, 4'd1);
    clearWrite = 1'b1;
    clearMask = 2'b01;
    @(negedge clk);
    clearWrite = 1'b0;
    check("R8 other bit clear keeps flag", {2'b0, statusFlags}, 4'b0010);
    clearWrite = 1'b1;
    clearMask = 2'b10;
    @(negedge clk);
    clearWrite = 1'b0;
    clearMask = 2'b00;
    check("R8 clear later", {2'b0, statusFlags}, 4'd0);

    // random trials
    for (int n = 0; n < 60; n++) begin
      trial(int'($urandom % 3), 1'($urandom), 2'($urandom), 2'($urandom),
            1 + int'($urandom % 20));
    end

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule